// File: doc/BRIEF.md
# Masked Pin Output and Enable Update Logic

This block holds the value that a general-purpose I/O port drives on its pins and the per-pin output-enable word. Software can change each of the two words in three ways. A direct write replaces the whole word. A low-half masked write or a high-half masked write changes one half of the word, and only the bits that the write selects. Because the mask travels in the same write word as the new bits, software can set or clear any group of pins in a single write, with no read-modify-write and no race against other users of the same word.

The port on the software side is plain. There is one write-data bus and six write strobes: direct, low-half and high-half, for the data word and for the enable word. There are six read-back values, one for each access window. The pin-side outputs carry the current data word and the current enable word.

Top module: `pin_out_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, both stored words are zero: pinOut and pinOe are 0, every read-back value is 0, and all pins start as inputs.
- R2: A direct strobe (dirOutWe or dirOeWe) loads all 32 bits of its word from wrData.
- R3: A masked write takes its new bits from wrData[15:0] and its mask from wrData[31:16]. A bit whose mask bit is 1 takes the new value, and a bit whose mask bit is 0 keeps its old value. On a low-half write, mask bit k and data bit k apply to word bit k.
- R4: A low-half masked write (loOutWe or loOeWe) leaves bits [31:16] of its word unchanged.
- R5: A high-half masked write (hiOutWe or hiOeWe) applies mask bit k and data bit k to word bit 16+k, and leaves bits [15:0] unchanged.
- R6: When the direct strobe of a word is active in the same cycle as one of its masked strobes, the direct write alone takes effect on that word.
- R7: Low-half and high-half masked strobes of the same word in one cycle both take effect, each on its own half.
- R8: The data-word window reads loOutRd and hiOutRd return the current half of the data word in bits [15:0] and zero in bits [31:16]. outRd returns the whole data word.
- R9: The enable-word window reads loOeRd and hiOeRd return the current half of the enable word in bits [15:0]. In bits [31:16] they return the mask from the last write strobe of that window, and this mask is captured even when a direct write wins that cycle. Both masks reset to zero. oeRd returns the whole enable word.
- R10: A write is seen on the pins and on every read-back value from the first rising clock edge after the cycle in which its strobe is high, and not before.
- R11: A write to one word never changes the other word. In a cycle with no strobe for a word, that word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrData | input | 32 | Write word shared by all six strobes |
| dirOutWe | input | 1 | Direct write of the data word |
| loOutWe | input | 1 | Masked write of data word bits [15:0] |
| hiOutWe | input | 1 | Masked write of data word bits [31:16] |
| dirOeWe | input | 1 | Direct write of the enable word |
| loOeWe | input | 1 | Masked write of enable word bits [15:0] |
| hiOeWe | input | 1 | Masked write of enable word bits [31:16] |
| outRd | output | 32 | Whole data word |
| loOutRd | output | 32 | Data low window read |
| hiOutRd | output | 32 | Data high window read |
| oeRd | output | 32 | Whole enable word |
| loOeRd | output | 32 | Enable low window read: last mask and current half |
| hiOeRd | output | 32 | Enable high window read: last mask and current half |
| pinOut | output | 32 | Value driven onto the pins |
| pinOe | output | 32 | Per-pin output enable |

## Verification
Every result of this block is due one clock edge after its strobe. One register stands between a strobe and the pins or the read-back values, and everything after that register is combinational. The bench drives strobes just after a rising edge and keeps its reference model in step on the same edge. It compares every output at the following falling edge, so each comparison falls in the first cycle in which the new value is due. A check made in the cycle a strobe is still high would see the old value, so the per-cycle comparison also catches a write that takes effect too early or too late.

// File: rtl/pin_out_pkg.sv
package pin_out_pkg;

  localparam int NUM_TGT = 2;
  localparam int TGT_OUT = 0;
  localparam int TGT_OE  = 1;

  // Per-word update strobes passed from control to datapath
  typedef struct packed {
    logic full;   // whole-word load
    logic lo;     // merge into low half
    logic hi;     // merge into high half
    logic capLo;  // capture low-window mask
    logic capHi;  // capture high-window mask
  } wrSel_t;

endpackage

// File: rtl/pin_out_ctl.sv
module pin_out_ctl
  import pin_out_pkg::*;
#(
  parameter int NTGT = NUM_TGT
) (
  input  logic [NTGT-1:0] dirWe,
  input  logic [NTGT-1:0] loWe,
  input  logic [NTGT-1:0] hiWe,
  output wrSel_t [NTGT-1:0] sel
);

  for (genvar t = 0; t < NTGT; t++) begin : g_tgt
    always_comb begin
      sel[t].full  = dirWe[t];
      // a direct write wins over the masked windows of the same word
      sel[t].lo    = loWe[t] & ~dirWe[t];
      sel[t].hi    = hiWe[t] & ~dirWe[t];
      // window masks are captured on every window strobe
      sel[t].capLo = loWe[t];
      sel[t].capHi = hiWe[t];
    end
  end

endmodule

// File: rtl/pin_out_dp.sv
module pin_out_dp
  import pin_out_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter bit MASK_READ = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrSel_t           sel,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] wordQ,
  output logic [WIDTH-1:0] loRd,
  output logic [WIDTH-1:0] hiRd
);

  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] wordNext;
  logic [HALF-1:0]  newBits;
  logic [HALF-1:0]  maskBits;
  logic [HALF-1:0]  mergedLo;
  logic [HALF-1:0]  mergedHi;

  assign newBits  = wrData[HALF-1:0];
  assign maskBits = wrData[WIDTH-1:HALF];
  assign mergedLo = (wordQ[HALF-1:0]     & ~maskBits) | (newBits & maskBits);
  assign mergedHi = (wordQ[WIDTH-1:HALF] & ~maskBits) | (newBits & maskBits);

  always_comb begin
    wordNext = wordQ;
    if (sel.full) begin
      wordNext = wrData;
    end else begin
      if (sel.lo) wordNext[HALF-1:0]     = mergedLo;
      if (sel.hi) wordNext[WIDTH-1:HALF] = mergedHi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) wordQ <= '0;
    else       wordQ <= wordNext;
  end

  if (MASK_READ) begin : g_maskRead
    logic [HALF-1:0] loMaskQ;
    logic [HALF-1:0] hiMaskQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        loMaskQ <= '0;
        hiMaskQ <= '0;
      end else begin
        if (sel.capLo) loMaskQ <= maskBits;
        if (sel.capHi) hiMaskQ <= maskBits;
      end
    end
    assign loRd = {loMaskQ, wordQ[HALF-1:0]};
    assign hiRd = {hiMaskQ, wordQ[WIDTH-1:HALF]};
  end else begin : g_plainRead
    assign loRd = {{HALF{1'b0}}, wordQ[HALF-1:0]};
    assign hiRd = {{HALF{1'b0}}, wordQ[WIDTH-1:HALF]};
  end

  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    sel.full |=> wordQ == $past(wrData)); // R2

  AST_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    sel.lo |=> ((wordQ[HALF-1:0] ^ $past(wordQ[HALF-1:0])) & ~$past(wrData[WIDTH-1:HALF])) == '0); // R3

  AST_LO_HOLDS_HI: assert property (@(posedge clk) disable iff (!rstN)
    (sel.lo && !sel.hi && !sel.full) |=> wordQ[WIDTH-1:HALF] == $past(wordQ[WIDTH-1:HALF])); // R4

  AST_HI_HOLDS_LO: assert property (@(posedge clk) disable iff (!rstN)
    (sel.hi && !sel.lo && !sel.full) |=> wordQ[HALF-1:0] == $past(wordQ[HALF-1:0])); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(sel.full || sel.lo || sel.hi) |=> $stable(wordQ)); // R11

endmodule

// File: rtl/pin_out_ctrl.sv
module pin_out_ctrl
  import pin_out_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] wrData,
  input  logic             dirOutWe,
  input  logic             loOutWe,
  input  logic             hiOutWe,
  input  logic             dirOeWe,
  input  logic             loOeWe,
  input  logic             hiOeWe,
  output logic [WIDTH-1:0] outRd,
  output logic [WIDTH-1:0] loOutRd,
  output logic [WIDTH-1:0] hiOutRd,
  output logic [WIDTH-1:0] oeRd,
  output logic [WIDTH-1:0] loOeRd,
  output logic [WIDTH-1:0] hiOeRd,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);

  wrSel_t [NUM_TGT-1:0] sel;
  logic   [WIDTH-1:0]   wordQ [NUM_TGT];
  logic   [WIDTH-1:0]   loRd  [NUM_TGT];
  logic   [WIDTH-1:0]   hiRd  [NUM_TGT];

  pin_out_ctl #(.NTGT(NUM_TGT)) i_ctl (
    .dirWe ({dirOeWe, dirOutWe}),
    .loWe  ({loOeWe,  loOutWe}),
    .hiWe  ({hiOeWe,  hiOutWe}),
    .sel   (sel)
  );

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_word
    pin_out_dp #(
      .WIDTH     (WIDTH),
      .MASK_READ (t == TGT_OE)
    ) i_dp (
      .clk    (clk),
      .rstN   (rstN),
      .sel    (sel[t]),
      .wrData (wrData),
      .wordQ  (wordQ[t]),
      .loRd   (loRd[t]),
      .hiRd   (hiRd[t])
    );
  end

  assign outRd   = wordQ[TGT_OUT];
  assign loOutRd = loRd[TGT_OUT];
  assign hiOutRd = hiRd[TGT_OUT];
  assign oeRd    = wordQ[TGT_OE];
  assign loOeRd  = loRd[TGT_OE];
  assign hiOeRd  = hiRd[TGT_OE];
  assign pinOut  = wordQ[TGT_OUT];
  assign pinOe   = wordQ[TGT_OE];

endmodule

// File: tb/test_pin_out_ctrl.sv
`timescale 1ns/1ps
module test_pin_out_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] wrData = '0;
  logic [5:0]  stb = '0;  // {hiOe, loOe, dirOe, hiOut, loOut, dirOut}
  logic [31:0] outRd, loOutRd, hiOutRd, oeRd, loOeRd, hiOeRd, pinOut, pinOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_out_ctrl i_pin_out_ctrl (
    .clk(clk), .rstN(rstN), .wrData(wrData),
    .dirOutWe(stb[0]), .loOutWe(stb[1]), .hiOutWe(stb[2]),
    .dirOeWe(stb[3]),  .loOeWe(stb[4]),  .hiOeWe(stb[5]),
    .outRd(outRd), .loOutRd(loOutRd), .hiOutRd(hiOutRd),
    .oeRd(oeRd), .loOeRd(loOeRd), .hiOeRd(hiOeRd),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  // reference model
  logic [31:0] mOut = '0, mOe = '0;
  logic [15:0] mLoMask = '0, mHiMask = '0;

  function automatic logic [31:0] upd(logic [31:0] old, logic full, logic lo, logic hi, logic [31:0] d);
    logic [31:0] r = old;
    if (full) return d;
    for (int k = 0; k < 16; k++) begin
      if (lo && d[16+k]) r[k]    = d[k];
      if (hi && d[16+k]) r[16+k] = d[k];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOut <= '0; mOe <= '0; mLoMask <= '0; mHiMask <= '0;
    end else begin
      mOut <= upd(mOut, stb[0], stb[1], stb[2], wrData);
      mOe  <= upd(mOe,  stb[3], stb[4], stb[5], wrData);
      if (stb[4]) mLoMask <= wrData[31:16];
      if (stb[5]) mHiMask <= wrData[31:16];
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " pinOut"},  pinOut,  mOut);
    check({tag, " pinOe"},   pinOe,   mOe);
    check({tag, " outRd"},   outRd,   mOut);
    check({tag, " oeRd"},    oeRd,    mOe);
    check({tag, " loOutRd"}, loOutRd, {16'h0, mOut[15:0]});
    check({tag, " hiOutRd"}, hiOutRd, {16'h0, mOut[31:16]});
    check({tag, " loOeRd"},  loOeRd,  {mLoMask, mOe[15:0]});
    check({tag, " hiOeRd"},  hiOeRd,  {mHiMask, mOe[31:16]});
  endtask

  // R10: per-cycle comparison against the model at each falling edge
  always @(negedge clk) if (rstN && !done) checkAll("R10");

  task automatic wr(logic [5:0] s, logic [31:0] d);
    @(posedge clk); #1;
    stb = s; wrData = d;
    @(negedge clk);
    check("R10 no early update", pinOut, mOut);
    @(posedge clk); #1;
    stb = '0; wrData = '0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 2000);
    check("watchdog", 32'd1, 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pinOut in reset", pinOut, 32'h0);
    check("R1 pinOe in reset", pinOe, 32'h0);
    @(posedge clk); #1; rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");
    // R2 direct loads
    wr(6'b000001, 32'hA5A5_3C3C);
    check("R2 data direct", pinOut, 32'hA5A5_3C3C);
    wr(6'b001000, 32'hFFFF_0000);
    check("R2 enable direct", pinOe, 32'hFFFF_0000);
    check("R11 data untouched by enable write", pinOut, 32'hA5A5_3C3C);
    // R3/R4 low masked data
    wr(6'b000010, 32'h00FF_1234);
    check("R3 low merge", pinOut[15:0], 16'h3C34);
    check("R4 high kept", pinOut[31:16], 16'hA5A5);
    wr(6'b000010, 32'h0000_FFFF);
    check("R3 zero mask keeps", pinOut, 32'hA5A5_3C34);
    // R5 high masked data
    wr(6'b000100, 32'hF000_0BCD);
    check("R5 high merge", pinOut, 32'h05A5_3C34);
    // R8 window read format
    check("R8 low window", loOutRd, 32'h0000_3C34);
    check("R8 high window", hiOutRd, 32'h0000_05A5);
    // R7 both halves same cycle
    wr(6'b000110, 32'hFFFF_0000);
    check("R7 both halves", pinOut, 32'h0000_0000);
    // R6 direct beats masked
    wr(6'b000111, 32'h0F0F_1111);
    check("R6 direct wins data", pinOut, 32'h0F0F_1111);
    // R9 enable windows with mask capture
    wr(6'b010000, 32'h8001_FFFF);
    check("R9 low enable window", loOeRd, 32'h8001_8001);
    wr(6'b100000, 32'h00F0_0000);
    check("R9 high enable window", hiOeRd, 32'h00F0_FF0F);
    check("R9 enable word", oeRd, 32'hFF0F_8001);
    wr(6'b111000, 32'h1234_5678);
    check("R6 direct wins enable", pinOe, 32'h1234_5678);
    check("R9 mask captured on lost write", loOeRd, 32'h1234_5678);
    check("R11 data unaffected", pinOut, 32'h0F0F_1111);
    // R11 idle cycles hold
    repeat (4) @(negedge clk);
    check("R11 idle data", pinOut, 32'h0F0F_1111);
    check("R11 idle enable", pinOe, 32'h1234_5678);
    // mixed sweep against the model
    for (int i = 0; i < 40; i++) wr(6'(i * 7 + 3), 32'h9E37_79B9 * (i + 1));
    // R1 reset again
    @(posedge clk); #1; rstN = 1'b0;
    @(posedge clk); #1; rstN = 1'b1;
    @(negedge clk);
    check("R1 after re-reset out", pinOut, 32'h0);
    check("R1 after re-reset mask", loOeRd, 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule